// File: doc/BRIEF.md
# CAN Controller Operating-Mode Sequencer

This block decides which operating mode a CAN controller is in. Software places a 3-bit mode request on `reqMode`. The block reports the mode actually in force on `curMode`, using the same encoding. A request is applied only when applying it is safe. Once the controller is active on the bus, a change waits for bus idle. Bus idle is a run of 11 consecutive recessive samples of the receive line, counted on `bitStrobe`, which pulses once per bit time. A switch into configuration is also held back while the transmitter reports a frame in flight.

From the mode in force, the block drives the controls the rest of the controller needs:
- transmit and receive enables;
- acknowledge and error-flag drive;
- the error-counter action;
- the configuration write lock;
- the internal loopback select;
- ownership of the transmit and receive pins.

The block also holds the pending transmit request. After entry into a mode that may transmit, that request is kept back until 11 further recessive bits have been seen. If disable is requested during this hold-off, the request is dropped and an abort flag is raised. In disable mode, a dominant sample on the receive line produces a wake pulse.

Top module: `canModeSeq`

## Requirements
- R1: After reset `curMode` is 100 (configuration), `cfgWriteEnable` is 1, `errCtl` is 10 (clear) and `txEnable` is 0.
- R2: Mode codes are 000 normal, 001 disable, 010 loopback, 011 listen-only, 100 configuration and 111 listen-all. Request codes 101 and 110 leave `curMode` unchanged.
- R3: While `curMode` is configuration or disable, a different valid request appears on `curMode` one clock later.
- R4: In normal, loopback, listen-only or listen-all mode, a different request is applied only once 11 consecutive recessive strobed samples have been seen. A dominant sample restarts the count, and the change appears one clock after the eleventh sample.
- R5: While `txBusy` is 1, a request for configuration is held and `curMode` does not become 100. The request is applied one clock after `txBusy` falls.
- R6: Normal mode drives `txEnable`, `rxEnable`, `ackErrEnable`, `txPinOwn` and `rxPinOwn` to 1, with `errCtl` 00 (count).
- R7: Listen-only mode drives `rxEnable` and `rxPinOwn` to 1, `txEnable`, `ackErrEnable` and `txPinOwn` to 0, and `errCtl` to 01 (freeze).
- R8: Listen-all mode drives `errIgnore` to 1 and `rxEnable` to 1. It drives `txEnable`, `ackErrEnable` and `txPinOwn` to 0, and `errCtl` to 01 (freeze).
- R9: Loopback mode drives `loopbackSel` and `txEnable` to 1, and releases both pins (`txPinOwn` and `rxPinOwn` are 0).
- R10: Configuration mode drives `errCtl` to 10 and `cfgWriteEnable` to 1, with transmit and receive disabled. Disable mode drives `errCtl` to 01, disables transmit and receive, and releases both pins. `cfgWriteEnable` is 0 in every mode except configuration.
- R11: A request raised by `txReqSet` sets `txPending`. `txStart` rises only once 11 consecutive recessive samples have been seen since entry into normal or loopback mode. `txPending` clears one clock after `txStart`.
- R12: A disable request during the hold-off, while a transmit is pending, clears `txPending` and sets `txAbortFlag` one clock later. A later `txReqSet` clears the flag.
- R13: In disable mode, `wakeEvent` is 1 exactly while `bitStrobe` is 1 and `rxSample` is 0 (dominant).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitStrobe | input | 1 | One pulse per bit time; qualifies `rxSample` |
| rxSample | input | 1 | Sampled bus level, 1 = recessive |
| reqMode | input | 3 | Requested mode |
| txReqSet | input | 1 | Pulse that raises a transmit request |
| txBusy | input | 1 | A frame is being transmitted |
| curMode | output | 3 | Mode in force |
| txEnable | output | 1 | Transmitter may drive the bus |
| rxEnable | output | 1 | Receiver active |
| ackErrEnable | output | 1 | Acknowledge and error flags may be driven |
| errCtl | output | 2 | Error counter action: 00 count, 01 freeze, 10 clear |
| errIgnore | output | 1 | Receive path ignores all errors |
| cfgWriteEnable | output | 1 | Configuration registers writable |
| loopbackSel | output | 1 | Internal transmit routed to internal receive |
| txPinOwn | output | 1 | Controller owns the transmit pin |
| rxPinOwn | output | 1 | Controller owns the receive pin |
| txPending | output | 1 | Transmit request outstanding |
| txStart | output | 1 | Transmission may start now |
| txAbortFlag | output | 1 | Pending request was aborted by disable |
| wakeEvent | output | 1 | Dominant sample seen while disabled |

## Verification
A wrong recessive-run count shows up as a mode change at the wrong time. The change comes either one clock after a strobe that should not have completed the idle run, or not at all. A mode register holding the wrong value shows on every decoded control output in the same cycle, so each mode's output set is checked at the first negative edge after entry. A wrong hold-off or pending state shows as `txStart` at the wrong sample, or as `txPending` and `txAbortFlag` wrong one clock after a disable request. The bench therefore samples these outputs at the exact cycle where they are due.

// File: rtl/canModePkg.sv
package canModePkg;

  typedef enum logic [2:0] {
    MODE_NORMAL     = 3'b000,
    MODE_DISABLE    = 3'b001,
    MODE_LOOPBACK   = 3'b010,
    MODE_LISTEN     = 3'b011,
    MODE_CONFIG     = 3'b100,
    MODE_LISTEN_ALL = 3'b111
  } modeT;

  localparam logic [1:0] ERR_COUNT  = 2'b00;
  localparam logic [1:0] ERR_FREEZE = 2'b01;
  localparam logic [1:0] ERR_CLEAR  = 2'b10;

  // strobes from the control to the datapath
  typedef struct packed {
    logic enterTx;   // switching into a mode that may transmit
    logic abortTx;   // drop the pending request
  } dpStrobeT;

endpackage

// File: rtl/recessiveRun.sv
module recessiveRun #(
  parameter int LIMIT = 11
) (
  input  logic clk,
  input  logic rstN,
  input  logic restart,
  input  logic bitStrobe,
  input  logic rxSample,
  output logic done
);
  localparam int CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] TOP = CNT_W'(LIMIT);

  logic [CNT_W-1:0] count;

  always_ff @(posedge clk) begin
    if (!rstN || restart) begin
      count <= '0;
    end else if (bitStrobe) begin
      if (!rxSample) count <= '0;
      else if (count != TOP) count <= count + 1'b1;
    end
  end

  assign done = (count == TOP);

  // R4
  run_saturates_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= TOP);

  // R4
  dominant_restarts_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bitStrobe && !rxSample) |=> !done);

endmodule

// File: rtl/canModeDatapath.sv
module canModeDatapath
  import canModePkg::*;
#(
  parameter int IDLE_BITS = 11
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     bitStrobe,
  input  logic     rxSample,
  input  logic     txReqSet,
  input  logic     txBusy,
  input  logic     txAllowed,
  input  dpStrobeT strobes,
  output logic     busIdle,
  output logic     holdDone,
  output logic     txPending,
  output logic     txAbortFlag,
  output logic     txStart
);
  logic [1:0] runDone;
  logic [1:0] runRestart;

  assign runRestart = {strobes.enterTx, 1'b0};

  // run 0 watches bus idle, run 1 times the transmit hold-off
  for (genvar g = 0; g < 2; g++) begin : gRun
    recessiveRun #(.LIMIT(IDLE_BITS)) uRun (
      .clk      (clk),
      .rstN     (rstN),
      .restart  (runRestart[g]),
      .bitStrobe(bitStrobe),
      .rxSample (rxSample),
      .done     (runDone[g])
    );
  end

  assign busIdle  = runDone[0];
  assign holdDone = runDone[1];
  assign txStart  = txPending && txAllowed && holdDone && !txBusy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txPending   <= 1'b0;
      txAbortFlag <= 1'b0;
    end else begin
      if (strobes.abortTx)  txPending <= 1'b0;
      else if (txReqSet)    txPending <= 1'b1;
      else if (txStart)     txPending <= 1'b0;

      if (strobes.abortTx)  txAbortFlag <= 1'b1;
      else if (txReqSet)    txAbortFlag <= 1'b0;
    end
  end

  // R12
  abort_drops_request_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.abortTx |=> (!txPending && txAbortFlag));

  // R11
  start_consumes_request_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txStart && !txReqSet && !strobes.abortTx) |=> !txPending);

endmodule

// File: rtl/canModeControl.sv
module canModeControl
  import canModePkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] reqMode,
  input  logic       txBusy,
  input  logic       busIdle,
  input  logic       holdDone,
  input  logic       txPending,
  input  logic       bitStrobe,
  input  logic       rxSample,
  output logic [2:0] curMode,
  output dpStrobeT   strobes,
  output logic       txEnable,
  output logic       rxEnable,
  output logic       ackErrEnable,
  output logic [1:0] errCtl,
  output logic       errIgnore,
  output logic       cfgWriteEnable,
  output logic       loopbackSel,
  output logic       txPinOwn,
  output logic       rxPinOwn,
  output logic       wakeEvent
);
  modeT modeQ;
  logic reqValid, curActive, reqTxCap, curTxCap, modeGo;

  assign reqValid  = (reqMode != 3'b101) && (reqMode != 3'b110);
  assign curActive = (modeQ != MODE_CONFIG) && (modeQ != MODE_DISABLE);
  assign reqTxCap  = (reqMode == MODE_NORMAL) || (reqMode == MODE_LOOPBACK);
  assign curTxCap  = (modeQ == MODE_NORMAL) || (modeQ == MODE_LOOPBACK);

  assign modeGo = reqValid && (reqMode != modeQ)
               && (!curActive || busIdle)
               && !((reqMode == MODE_CONFIG) && txBusy);

  assign strobes.enterTx = modeGo && reqTxCap;
  assign strobes.abortTx = (reqMode == MODE_DISABLE) && curTxCap && !holdDone && txPending;

  always_ff @(posedge clk) begin
    if (!rstN)       modeQ <= MODE_CONFIG;
    else if (modeGo) modeQ <= modeT'(reqMode);
  end

  assign curMode   = modeQ;
  assign wakeEvent = (modeQ == MODE_DISABLE) && bitStrobe && !rxSample;

  always_comb begin
    txEnable = 1'b0; rxEnable = 1'b0; ackErrEnable = 1'b0;
    errCtl = ERR_FREEZE; errIgnore = 1'b0; cfgWriteEnable = 1'b0;
    loopbackSel = 1'b0; txPinOwn = 1'b0; rxPinOwn = 1'b0;
    case (modeQ)
      MODE_NORMAL: begin
        txEnable = 1'b1; rxEnable = 1'b1; ackErrEnable = 1'b1;
        errCtl = ERR_COUNT; txPinOwn = 1'b1; rxPinOwn = 1'b1;
      end
      MODE_LOOPBACK: begin
        txEnable = 1'b1; rxEnable = 1'b1; ackErrEnable = 1'b1;
        errCtl = ERR_COUNT; loopbackSel = 1'b1;
      end
      MODE_LISTEN: begin
        rxEnable = 1'b1; rxPinOwn = 1'b1;
      end
      MODE_LISTEN_ALL: begin
        rxEnable = 1'b1; rxPinOwn = 1'b1; errIgnore = 1'b1;
      end
      MODE_CONFIG: begin
        errCtl = ERR_CLEAR; cfgWriteEnable = 1'b1;
        txPinOwn = 1'b1; rxPinOwn = 1'b1;
      end
      default: ;  // disable: everything released, counters frozen
    endcase
  end

  // R2
  reserved_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((reqMode == 3'b101) || (reqMode == 3'b110)) |=> $stable(curMode));

  // R4
  idle_gates_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    (curActive && !busIdle) |=> $stable(curMode));

  // R5
  config_waits_tx_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((curMode != MODE_CONFIG) && txBusy) |=> (curMode != MODE_CONFIG));

endmodule

// File: rtl/canModeSeq.sv
module canModeSeq
  import canModePkg::*;
#(
  parameter int IDLE_BITS = 11
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitStrobe,
  input  logic       rxSample,
  input  logic [2:0] reqMode,
  input  logic       txReqSet,
  input  logic       txBusy,
  output logic [2:0] curMode,
  output logic       txEnable,
  output logic       rxEnable,
  output logic       ackErrEnable,
  output logic [1:0] errCtl,
  output logic       errIgnore,
  output logic       cfgWriteEnable,
  output logic       loopbackSel,
  output logic       txPinOwn,
  output logic       rxPinOwn,
  output logic       txPending,
  output logic       txStart,
  output logic       txAbortFlag,
  output logic       wakeEvent
);
  dpStrobeT strobes;
  logic busIdle, holdDone, txEnableInt;

  assign txEnable = txEnableInt;

  canModeControl uCtrl (
    .clk(clk), .rstN(rstN), .reqMode(reqMode), .txBusy(txBusy),
    .busIdle(busIdle), .holdDone(holdDone), .txPending(txPending),
    .bitStrobe(bitStrobe), .rxSample(rxSample), .curMode(curMode),
    .strobes(strobes), .txEnable(txEnableInt), .rxEnable(rxEnable),
    .ackErrEnable(ackErrEnable), .errCtl(errCtl), .errIgnore(errIgnore),
    .cfgWriteEnable(cfgWriteEnable), .loopbackSel(loopbackSel),
    .txPinOwn(txPinOwn), .rxPinOwn(rxPinOwn), .wakeEvent(wakeEvent)
  );

  canModeDatapath #(.IDLE_BITS(IDLE_BITS)) uData (
    .clk(clk), .rstN(rstN), .bitStrobe(bitStrobe), .rxSample(rxSample),
    .txReqSet(txReqSet), .txBusy(txBusy), .txAllowed(txEnableInt),
    .strobes(strobes), .busIdle(busIdle), .holdDone(holdDone),
    .txPending(txPending), .txAbortFlag(txAbortFlag), .txStart(txStart)
  );

endmodule

// File: tb/test_canModeSeq.sv
module test_canModeSeq;

  logic clk = 1'b0;
  logic rstN = 1'b0, bitStrobe = 1'b0, rxSample = 1'b1, txReqSet = 1'b0, txBusy = 1'b0;
  logic [2:0] reqMode = 3'b100;
  logic [2:0] curMode;
  logic [1:0] errCtl;
  logic txEnable, rxEnable, ackErrEnable, errIgnore, cfgWriteEnable, loopbackSel;
  logic txPinOwn, rxPinOwn, txPending, txStart, txAbortFlag, wakeEvent;

  always #2 clk = ~clk;  // 250 MHz

  canModeSeq i_canModeSeq (
    .clk(clk), .rstN(rstN), .bitStrobe(bitStrobe), .rxSample(rxSample),
    .reqMode(reqMode), .txReqSet(txReqSet), .txBusy(txBusy), .curMode(curMode),
    .txEnable(txEnable), .rxEnable(rxEnable), .ackErrEnable(ackErrEnable),
    .errCtl(errCtl), .errIgnore(errIgnore), .cfgWriteEnable(cfgWriteEnable),
    .loopbackSel(loopbackSel), .txPinOwn(txPinOwn), .rxPinOwn(rxPinOwn),
    .txPending(txPending), .txStart(txStart), .txAbortFlag(txAbortFlag),
    .wakeEvent(wakeEvent)
  );

  typedef enum int {S_MODE, S_TXEN, S_RXEN, S_ACK, S_ERR, S_IGN, S_CFG, S_LOOP,
                    S_TXPIN, S_RXPIN, S_PEND, S_START, S_ABORT, S_WAKE} selT;
  typedef struct { string req; selT sel; int exp; } itemT;

  itemT q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  function automatic int observe(selT s);
    case (s)
      S_MODE:  return int'(curMode);
      S_TXEN:  return int'(txEnable);
      S_RXEN:  return int'(rxEnable);
      S_ACK:   return int'(ackErrEnable);
      S_ERR:   return int'(errCtl);
      S_IGN:   return int'(errIgnore);
      S_CFG:   return int'(cfgWriteEnable);
      S_LOOP:  return int'(loopbackSel);
      S_TXPIN: return int'(txPinOwn);
      S_RXPIN: return int'(rxPinOwn);
      S_PEND:  return int'(txPending);
      S_START: return int'(txStart);
      S_ABORT: return int'(txAbortFlag);
      default: return int'(wakeEvent);
    endcase
  endfunction

  // monitor: compares queued expectations 1 ns after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        itemT e;
        int act;
        e = q.pop_front();
        act = observe(e.sel);
        checks++;
        if (act != e.exp) begin
          errors++;
          $display("FAIL %s %s actual %0d expected %0d", e.req, e.sel.name(), act, e.exp);
        end
      end
    end
  end

  task automatic expect_val(input string req, input selT sel, input int exp);
    itemT e;
    e.req = req; e.sel = sel; e.exp = exp;
    q.push_back(e);
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic bitSample(input logic lvl);
    bitStrobe = 1'b1; rxSample = lvl;
    tick();
    bitStrobe = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements) actual hung expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    // R1 reset state
    expect_val("R1", S_MODE, 4); expect_val("R1", S_CFG, 1);
    expect_val("R1", S_ERR, 2);  expect_val("R1", S_TXEN, 0);

    // R3 config -> normal at once
    reqMode = 3'b000; tick();
    expect_val("R3", S_MODE, 0);
    expect_val("R6", S_TXEN, 1); expect_val("R6", S_RXEN, 1); expect_val("R6", S_ACK, 1);
    expect_val("R6", S_ERR, 0);  expect_val("R6", S_TXPIN, 1); expect_val("R6", S_RXPIN, 1);
    expect_val("R10", S_CFG, 0);

    // R11 hold-off of 11 recessive bits
    txReqSet = 1'b1; tick(); txReqSet = 1'b0;
    expect_val("R11", S_PEND, 1); expect_val("R11", S_START, 0);
    for (int i = 0; i < 10; i++) bitSample(1'b1);
    expect_val("R11", S_START, 0);
    bitSample(1'b1);
    expect_val("R11", S_START, 1);
    tick();
    expect_val("R11", S_START, 0); expect_val("R11", S_PEND, 0);

    // R4 change waits for bus idle
    bitSample(1'b0);
    reqMode = 3'b011; tick(); tick();
    expect_val("R4", S_MODE, 0);
    for (int i = 0; i < 10; i++) bitSample(1'b1);
    expect_val("R4", S_MODE, 0);
    bitSample(1'b1);
    expect_val("R4", S_MODE, 0);
    tick();
    expect_val("R4", S_MODE, 3);
    expect_val("R7", S_TXEN, 0); expect_val("R7", S_RXEN, 1); expect_val("R7", S_ACK, 0);
    expect_val("R7", S_ERR, 1);  expect_val("R7", S_TXPIN, 0); expect_val("R7", S_RXPIN, 1);

    // R2 reserved codes
    reqMode = 3'b101; repeat (3) tick();
    expect_val("R2", S_MODE, 3);
    reqMode = 3'b110; repeat (2) tick();
    expect_val("R2", S_MODE, 3);

    // R9 loopback (bus already idle)
    reqMode = 3'b010; tick();
    expect_val("R9", S_MODE, 2); expect_val("R9", S_LOOP, 1); expect_val("R9", S_TXEN, 1);
    expect_val("R9", S_TXPIN, 0); expect_val("R9", S_RXPIN, 0);

    // R5 configuration held while transmitting
    txBusy = 1'b1; reqMode = 3'b100; repeat (3) tick();
    expect_val("R5", S_MODE, 2);
    txBusy = 1'b0; tick();
    expect_val("R5", S_MODE, 4);
    expect_val("R10", S_CFG, 1); expect_val("R10", S_ERR, 2);
    expect_val("R10", S_TXEN, 0); expect_val("R10", S_RXEN, 0);

    // R12 abort during hold-off
    reqMode = 3'b000; tick();
    expect_val("R3", S_MODE, 0);
    txReqSet = 1'b1; tick(); txReqSet = 1'b0;
    for (int i = 0; i < 3; i++) bitSample(1'b1);
    expect_val("R12", S_PEND, 1); expect_val("R12", S_START, 0);
    reqMode = 3'b001; tick();
    expect_val("R12", S_PEND, 0); expect_val("R12", S_ABORT, 1);
    expect_val("R12", S_MODE, 1);
    expect_val("R10", S_ERR, 1); expect_val("R10", S_TXEN, 0); expect_val("R10", S_RXEN, 0);
    expect_val("R10", S_TXPIN, 0); expect_val("R10", S_RXPIN, 0); expect_val("R10", S_CFG, 0);

    // R13 wake on dominant sample while disabled
    bitStrobe = 1'b1; rxSample = 1'b0;
    expect_val("R13", S_WAKE, 1);
    tick();
    rxSample = 1'b1;
    expect_val("R13", S_WAKE, 0);
    tick();
    bitStrobe = 1'b0;

    // R8 listen-all, R3 from disable
    reqMode = 3'b111; tick();
    expect_val("R3", S_MODE, 7);
    expect_val("R8", S_IGN, 1); expect_val("R8", S_ERR, 1); expect_val("R8", S_TXEN, 0);
    expect_val("R8", S_RXEN, 1); expect_val("R8", S_ACK, 0); expect_val("R8", S_TXPIN, 0);
    txReqSet = 1'b1; tick(); txReqSet = 1'b0;
    expect_val("R12", S_ABORT, 0); expect_val("R12", S_PEND, 1);
    expect_val("R11", S_START, 0);

    repeat (3) tick();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule